// File: doc/BRIEF.md
# Addressable Instruction Decoder with Branch Resolution

This block sits in the control path of an 18-bit ones' complement processor. Each cycle that its enable is high, it takes one instruction word and decodes it. It also takes a snapshot of the program counter, the accumulator, the live-register sign, the index register and an external level. One clock edge later it presents a registered set of outputs. These give the instruction class, whether addressing is indexed, which architectural registers and memory the instruction writes, whether a branch is taken, the next program counter, and whether execution needs one cycle or two. The register datapath and the memory stay outside the block; it only reports what should happen.

The five most significant bits of the word form the operation code and the low thirteen bits form the address. The opcode splits into three populated ranges (store, add/load and transfer) plus unused codes, which behave as no-ops. Zero tests on the accumulator and index register accept both ones' complement zeros. A transfer that branches finishes in one cycle, while one that falls through needs two.

Top module: `insn_branch_unit`

## Requirements
- R1: While reset is active and until the first enabled decode, next_pc is 0, taken, two_cycle, indexed and all four write strobes are 0, iclass is 3 and is_nop is 1.
- R2: The opcode is instr[17:13] and the address is instr[12:0]. iclass is 0 for opcodes 0-6 (store), 1 for 8-15 (add/load), 2 for 16-23 (transfer) and 3 with is_nop=1 for opcode 7 and 24-31.
- R3: indexed is 1 exactly for opcodes 1, 5, 9, 13, 15 and 21.
- R4: Opcode 16 branches iff ac[17] is 1. Opcode 23 branches iff lr_sign is 0.
- R5: Opcode 17 branches iff ac equals 18'h00000 or 18'h3FFFF.
- R6: Opcode 22 branches iff ext_level is 1. Opcode 19 branches iff xr is neither 14'h0000 nor 14'h3FFF.
- R7: Opcodes 18, 20 and 21 always branch. The target is the address field, except for opcode 21, whose target is (address + xr[12:0]) mod 8192.
- R8: When taken is 1, next_pc is the target. Otherwise, for every opcode, next_pc is (pc + 1) mod 8192, so 8191 wraps to 0.
- R9: two_cycle is 1 for a transfer that does not branch and for opcodes 1 and 5. It is 0 for everything else, including every taken transfer.
- R10: mem_wr is 1 for opcodes 0-6. ac_wr is 1 for opcodes 3, 8, 9, 14 and 15. lr_wr is 1 for opcodes 12 and 13. xr_wr is 1 for opcodes 10, 11 and 18, and for opcode 19 only when it branches.
- R11: Outputs change only on the clock edge where dec_en is 1 and reflect the inputs sampled at that edge. With dec_en at 0 they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dec_en | input | 1 | Decode enable; sample inputs this edge |
| instr | input | 18 | Instruction word |
| pc | input | 13 | Address of the current instruction |
| ac | input | 18 | Accumulator value |
| lr_sign | input | 1 | Sign bit of the live register |
| xr | input | 14 | Index register value |
| ext_level | input | 1 | External condition level, 1 = asserted |
| next_pc | output | 13 | Next program counter |
| taken | output | 1 | Transfer branches |
| two_cycle | output | 1 | Instruction needs two cycles |
| indexed | output | 1 | Address is modified by the index register |
| iclass | output | 2 | Instruction class |
| is_nop | output | 1 | Unused opcode |
| mem_wr | output | 1 | Memory word is written |
| ac_wr | output | 1 | Accumulator is written |
| lr_wr | output | 1 | Live register is written |
| xr_wr | output | 1 | Index register is written |

## Verification
The registered taken flag and next_pc are the only internal state that matters. A wrong branch condition or a stale register shows up at the ports one edge after the enabled decode: next_pc points to the target instead of pc+1, or the reverse. The two_cycle flag flips at the same time. A fault in the hold path shows up as outputs that change on an edge with dec_en low, so the bench compares them across such an edge.

// File: rtl/ibu_pkg.sv
package ibu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [1:0] {
    CL_STORE = 2'd0,
    CL_ADDLD = 2'd1,
    CL_XFER  = 2'd2,
    CL_NONE  = 2'd3
  } iclass_e;

  typedef enum logic [2:0] {
    C_NEVER  = 3'd0,
    C_ALWAYS = 3'd1,
    C_ACNEG  = 3'd2,
    C_ACZERO = 3'd3,
    C_XRNZ   = 3'd4,
    C_LEVEL  = 3'd5,
    C_LRPOS  = 3'd6
  } cond_e;

  typedef struct packed {
    iclass_e cls;
    logic    idx;
    logic    nop;
    logic    mw;
    logic    aw;
    logic    lw;
    logic    xw_fix;
    logic    xw_take;
    cond_e   cond;
  } ctl_t;
endpackage

// File: rtl/ibu_opdec.sv
module ibu_opdec
  import ibu_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output ctl_t            ctl
);
  always_comb begin
    ctl = '{cls: CL_NONE, idx: 1'b0, nop: 1'b0, mw: 1'b0, aw: 1'b0,
            lw: 1'b0, xw_fix: 1'b0, xw_take: 1'b0, cond: C_NEVER};
    if (op <= 5'd6) begin
      ctl.cls = CL_STORE;
      ctl.mw  = 1'b1;
    end else if (op >= 5'd8 && op <= 5'd15) begin
      ctl.cls = CL_ADDLD;
    end else if (op >= 5'd16 && op <= 5'd23) begin
      ctl.cls = CL_XFER;
    end else begin
      ctl.nop = 1'b1;
    end
    case (op)
      5'd1, 5'd5, 5'd9, 5'd13, 5'd15, 5'd21: ctl.idx = 1'b1;
      default: ;
    endcase
    case (op)
      5'd3, 5'd8, 5'd9, 5'd14, 5'd15: ctl.aw = 1'b1;
      default: ;
    endcase
    case (op)
      5'd12, 5'd13: ctl.lw = 1'b1;
      default: ;
    endcase
    case (op)
      5'd10, 5'd11, 5'd18: ctl.xw_fix = 1'b1;
      5'd19:               ctl.xw_take = 1'b1;
      default: ;
    endcase
    case (op)
      5'd16:               ctl.cond = C_ACNEG;
      5'd17:               ctl.cond = C_ACZERO;
      5'd18, 5'd20, 5'd21: ctl.cond = C_ALWAYS;
      5'd19:               ctl.cond = C_XRNZ;
      5'd22:               ctl.cond = C_LEVEL;
      5'd23:               ctl.cond = C_LRPOS;
      default:             ctl.cond = C_NEVER;
    endcase
  end
endmodule

// File: rtl/ibu_cond.sv
module ibu_cond
  import ibu_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int XR_W   = 14
) (
  input  cond_e             cond,
  input  logic [WORD_W-1:0] ac,
  input  logic              lr_sign,
  input  logic [XR_W-1:0]   xr,
  input  logic              ext_level,
  output logic              take
);
  logic ac_is_zero;
  logic xr_is_zero;

  assign ac_is_zero = (ac == '0) || (ac == '1);
  assign xr_is_zero = (xr == '0) || (xr == '1);

  always_comb begin
    case (cond)
      C_ALWAYS: take = 1'b1;
      C_ACNEG:  take = ac[WORD_W-1];
      C_ACZERO: take = ac_is_zero;
      C_XRNZ:   take = !xr_is_zero;
      C_LEVEL:  take = ext_level;
      C_LRPOS:  take = !lr_sign;
      default:  take = 1'b0;
    endcase
  end
endmodule

// File: rtl/ibu_nextpc.sv
module ibu_nextpc #(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] xr_lo,
  input  logic              idx,
  input  logic              take,
  output logic [ADDR_W-1:0] npc
);
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] seq;

  assign target = idx ? ADDR_W'(addr + xr_lo) : addr;
  assign seq    = ADDR_W'(pc + 1'b1);
  assign npc    = take ? target : seq;
endmodule

// File: rtl/insn_branch_unit.sv
module insn_branch_unit
  import ibu_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_en,
  input  logic [WORD_W-1:0] instr,
  input  logic [ADDR_W-1:0] pc,
  input  logic [WORD_W-1:0] ac,
  input  logic              lr_sign,
  input  logic [ADDR_W:0]   xr,
  input  logic              ext_level,
  output logic [ADDR_W-1:0] next_pc,
  output logic              taken,
  output logic              two_cycle,
  output logic              indexed,
  output logic [1:0]        iclass,
  output logic              is_nop,
  output logic              mem_wr,
  output logic              ac_wr,
  output logic              lr_wr,
  output logic              xr_wr
);
  localparam int XR_W = ADDR_W + 1;

  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  ctl_t              ctl;
  logic              take_c;
  logic [ADDR_W-1:0] npc_c;

  ibu_opdec u_opdec (
    .op  (instr[WORD_W-1 -: OP_W]),
    .ctl (ctl)
  );

  ibu_cond #(.WORD_W(WORD_W), .XR_W(XR_W)) u_cond (
    .cond      (ctl.cond),
    .ac        (ac),
    .lr_sign   (lr_sign),
    .xr        (xr),
    .ext_level (ext_level),
    .take      (take_c)
  );

  ibu_nextpc #(.ADDR_W(ADDR_W)) u_nextpc (
    .pc    (pc),
    .addr  (instr[ADDR_W-1:0]),
    .xr_lo (xr[ADDR_W-1:0]),
    .idx   (ctl.idx),
    .take  (take_c),
    .npc   (npc_c)
  );

  logic [ADDR_W-1:0] npc_d, npc_q;
  logic tk_d, tk_q, two_d, two_q, idx_d, idx_q, nop_d, nop_q;
  logic mw_d, mw_q, aw_d, aw_q, lw_d, lw_q, xw_d, xw_q;
  logic [1:0] cls_d, cls_q;

  always_comb begin
    npc_d = npc_q; tk_d = tk_q; two_d = two_q; idx_d = idx_q;
    nop_d = nop_q; cls_d = cls_q;
    mw_d = mw_q; aw_d = aw_q; lw_d = lw_q; xw_d = xw_q;
    if (dec_en) begin
      npc_d = npc_c;
      tk_d  = take_c;
      two_d = ((ctl.cls == CL_XFER) && !take_c) ||
              ((ctl.cls == CL_STORE) && ctl.idx);
      idx_d = ctl.idx;
      nop_d = ctl.nop;
      cls_d = ctl.cls;
      mw_d  = ctl.mw;
      aw_d  = ctl.aw;
      lw_d  = ctl.lw;
      xw_d  = ctl.xw_fix || (ctl.xw_take && take_c);
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      npc_q <= '0; tk_q <= 1'b0; two_q <= 1'b0; idx_q <= 1'b0;
      nop_q <= 1'b1; cls_q <= CL_NONE;
      mw_q <= 1'b0; aw_q <= 1'b0; lw_q <= 1'b0; xw_q <= 1'b0;
    end else begin
      npc_q <= npc_d; tk_q <= tk_d; two_q <= two_d; idx_q <= idx_d;
      nop_q <= nop_d; cls_q <= cls_d;
      mw_q <= mw_d; aw_q <= aw_d; lw_q <= lw_d; xw_q <= xw_d;
    end
  end

  assign next_pc   = npc_q;
  assign taken     = tk_q;
  assign two_cycle = two_q;
  assign indexed   = idx_q;
  assign iclass    = cls_q;
  assign is_nop    = nop_q;
  assign mem_wr    = mw_q;
  assign ac_wr     = aw_q;
  assign lr_wr     = lw_q;
  assign xr_wr     = xw_q;

  // R9
  taken_single_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    taken |-> !two_cycle);

  // R2
  taken_class_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    taken |-> (iclass == CL_XFER));

  // R10
  memwr_class_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_wr |-> (iclass == CL_STORE));

  // R7
  always_branch_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (dec_en && ctl.cond == C_ALWAYS) |=> taken);

  // R8
  nop_advance_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (dec_en && ctl.nop) |=> (next_pc == ADDR_W'($past(pc) + 1'b1)));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !dec_en |=> ($stable(next_pc) && $stable(taken) && $stable(iclass)));
endmodule

// File: tb/insn_branch_unit_bench.sv
module insn_branch_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_en = 1'b0;
  logic [17:0] instr = '0;
  logic [12:0] pc = '0;
  logic [17:0] ac = '0;
  logic        lr_sign = 1'b0;
  logic [13:0] xr = '0;
  logic        ext_level = 1'b0;
  logic [12:0] next_pc;
  logic        taken, two_cycle, indexed, is_nop;
  logic [1:0]  iclass;
  logic        mem_wr, ac_wr, lr_wr, xr_wr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  insn_branch_unit u_insn_branch_unit (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .instr(instr), .pc(pc),
    .ac(ac), .lr_sign(lr_sign), .xr(xr), .ext_level(ext_level),
    .next_pc(next_pc), .taken(taken), .two_cycle(two_cycle),
    .indexed(indexed), .iclass(iclass), .is_nop(is_nop),
    .mem_wr(mem_wr), .ac_wr(ac_wr), .lr_wr(lr_wr), .xr_wr(xr_wr)
  );

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic issue(int op, int addr, int p, logic [17:0] a,
                       logic ls, logic [13:0] x, logic lv);
    instr = {5'(op), 13'(addr)};
    pc = 13'(p); ac = a; lr_sign = ls; xr = x; ext_level = lv;
    dec_en = 1'b1;
    @(negedge clk);
    dec_en = 1'b0;
  endtask

  task automatic expect_flow(string req, int npc, int tk, int two, int idx,
                             int cls, int nop);
    chk(req, "next_pc", next_pc, npc);
    chk(req, "taken", taken, tk);
    chk(req, "two_cycle", two_cycle, two);
    chk(req, "indexed", indexed, idx);
    chk(req, "iclass", iclass, cls);
    chk(req, "is_nop", is_nop, nop);
  endtask

  task automatic expect_wr(string req, int mw, int aw, int lw, int xw);
    chk(req, "mem_wr", mem_wr, mw);
    chk(req, "ac_wr", ac_wr, aw);
    chk(req, "lr_wr", lr_wr, lw);
    chk(req, "xr_wr", xr_wr, xw);
  endtask

  task automatic t_reset;
    expect_flow("R1", 0, 0, 0, 0, 3, 1);
    expect_wr("R1", 0, 0, 0, 0);
  endtask

  task automatic t_classes;
    issue(0, 5, 100, 18'h0, 1'b0, 14'h0, 1'b0);
    expect_flow("R2", 101, 0, 0, 0, 0, 0);
    expect_wr("R10", 1, 0, 0, 0);
    issue(1, 5, 100, 18'h0, 1'b0, 14'h0, 1'b0);
    expect_flow("R3", 101, 0, 1, 1, 0, 0);
    issue(3, 9, 7, 18'h0, 1'b0, 14'h0, 1'b0);
    expect_wr("R10", 1, 1, 0, 0);
    issue(8, 9, 7, 18'h0, 1'b0, 14'h0, 1'b0);
    expect_flow("R2", 8, 0, 0, 0, 1, 0);
    expect_wr("R10", 0, 1, 0, 0);
    issue(13, 9, 7, 18'h0, 1'b0, 14'h0, 1'b0);
    expect_flow("R3", 8, 0, 0, 1, 1, 0);
    expect_wr("R10", 0, 0, 1, 0);
    issue(11, 9, 7, 18'h0, 1'b0, 14'h0, 1'b0);
    expect_wr("R10", 0, 0, 0, 1);
    issue(7, 9, 40, 18'h3FFFF, 1'b0, 14'h0, 1'b1);
    expect_flow("R2", 41, 0, 0, 0, 3, 1);
    issue(24, 9, 40, 18'h0, 1'b0, 14'h5, 1'b1);
    expect_flow("R2", 41, 0, 0, 0, 3, 1);
    expect_wr("R2", 0, 0, 0, 0);
  endtask

  task automatic t_sign;
    issue(16, 'h100, 50, 18'h20000, 1'b0, 14'h0, 1'b0);
    expect_flow("R4", 'h100, 1, 0, 0, 2, 0);
    issue(16, 'h100, 50, 18'h1FFFF, 1'b0, 14'h0, 1'b0);
    expect_flow("R4", 51, 0, 1, 0, 2, 0);
    issue(23, 'h200, 60, 18'h0, 1'b0, 14'h0, 1'b0);
    expect_flow("R4", 'h200, 1, 0, 0, 2, 0);
    issue(23, 'h200, 60, 18'h0, 1'b1, 14'h0, 1'b0);
    expect_flow("R4", 61, 0, 1, 0, 2, 0);
  endtask

  task automatic t_zero;
    issue(17, 'h44, 10, 18'h00000, 1'b0, 14'h0, 1'b0);
    chk("R5", "taken +0", taken, 1);
    issue(17, 'h44, 10, 18'h3FFFF, 1'b0, 14'h0, 1'b0);
    chk("R5", "taken -0", taken, 1);
    chk("R5", "next_pc -0", next_pc, 'h44);
    issue(17, 'h44, 10, 18'h00001, 1'b0, 14'h0, 1'b0);
    expect_flow("R5", 11, 0, 1, 0, 2, 0);
  endtask

  task automatic t_level_index;
    issue(22, 'h30, 20, 18'h0, 1'b0, 14'h0, 1'b1);
    expect_flow("R6", 'h30, 1, 0, 0, 2, 0);
    issue(22, 'h30, 20, 18'h0, 1'b0, 14'h0, 1'b0);
    expect_flow("R6", 21, 0, 1, 0, 2, 0);
    issue(19, 'h31, 20, 18'h0, 1'b0, 14'h0000, 1'b0);
    expect_flow("R6", 21, 0, 1, 0, 2, 0);
    chk("R10", "xr_wr tix not taken", xr_wr, 0);
    issue(19, 'h31, 20, 18'h0, 1'b0, 14'h3FFF, 1'b0);
    chk("R6", "taken xr -0", taken, 0);
    issue(19, 'h31, 20, 18'h0, 1'b0, 14'h0005, 1'b0);
    expect_flow("R6", 'h31, 1, 0, 0, 2, 0);
    chk("R10", "xr_wr tix taken", xr_wr, 1);
  endtask

  task automatic t_always;
    issue(20, 'h1234, 3, 18'h0, 1'b1, 14'h0, 1'b0);
    expect_flow("R7", 'h1234, 1, 0, 0, 2, 0);
    issue(18, 'h0777, 3, 18'h0, 1'b1, 14'h0, 1'b0);
    expect_flow("R7", 'h0777, 1, 0, 0, 2, 0);
    chk("R10", "xr_wr tsx", xr_wr, 1);
    issue(21, 'h1FF0, 3, 18'h0, 1'b1, 14'h0020, 1'b0);
    expect_flow("R7", 'h0010, 1, 0, 1, 2, 0);
  endtask

  task automatic t_wrap;
    issue(0, 5, 'h1FFF, 18'h0, 1'b0, 14'h0, 1'b0);
    chk("R8", "next_pc wrap", next_pc, 0);
    issue(16, 5, 'h1FFF, 18'h0, 1'b0, 14'h0, 1'b0);
    chk("R8", "next_pc untaken wrap", next_pc, 0);
    chk("R9", "two_cycle untaken", two_cycle, 1);
  endtask

  task automatic t_hold;
    issue(20, 'h0ABC, 3, 18'h0, 1'b0, 14'h0, 1'b0);
    instr = {5'd7, 13'd0}; pc = 13'h0500; ac = 18'h1;
    @(negedge clk);
    @(negedge clk);
    expect_flow("R11", 'h0ABC, 1, 0, 0, 2, 0);
    expect_wr("R11", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_classes;
    t_sign;
    t_zero;
    t_level_index;
    t_always;
    t_wrap;
    t_hold;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule